// File: doc/BRIEF.md
# Instruction-Start Validator with Section Range Cache

This block decides whether a branch target address is the first byte of a genuine instruction. The block is used when a faster target cache has no entry for the address. A small on-chip cache of code-section descriptors is searched in parallel. Each descriptor holds the first byte address of a section, the last byte address, and the base address of that section's start-marker bitmap. The bitmap has one bit per code byte, so it takes one eighth of the code size. A set bit marks a byte where an instruction begins.

When exactly one descriptor covers the address, the block works out which bitmap byte it needs and reads that byte over a simple request/acknowledge port. It then reports the selected bit as the verdict. When no descriptor matches, the block asks an external agent for the covering descriptor and installs the reply in a round-robin victim slot. It then searches again. An address that no section covers is rejected. The block handles one check at a time. It returns a single-cycle completion pulse with the checked address, so that a confirmed result can be inserted into the target cache.

Top module: `csec_bitmap_chk`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `refill_req` are low and every cache slot is empty, so the first check of any address raises `refill_req`.
- R2: A descriptor covers an address when start <= address <= end. Both limits are inclusive: the start byte and the end byte are covered, and end+1 is not.
- R3: For a covering descriptor, with off = address - start, the block reads the byte at ptr + (off >> 3). The verdict `is_valid` equals bit (off & 7) of that byte, where bit 0 is the least significant bit.
- R4: On a cache miss, `refill_req` rises with `refill_addr` equal to the checked address. Both stay steady until `refill_ack`. A reply with `refill_hit` high is installed and the search is repeated.
- R5: If the refill reply has `refill_hit` low, or the repeated search still misses, the check completes with `is_valid` low and no memory read.
- R6: An address covered by a cached descriptor completes without any refill request.
- R7: Refills go to slots in round-robin order starting at slot 0. With 4 slots, the fifth descriptor installed replaces the first one.
- R8: If more than one cached descriptor covers the address, the check completes with `cfg_err` high, `is_valid` low and no memory read.
- R9: `busy` is high from the cycle after acceptance until completion. A `req_valid` seen while busy is ignored and produces no second completion.
- R10: `done` is a one-cycle pulse, `res_addr` carries the accepted address, and `is_valid` and `cfg_err` are low whenever `done` is low.
- R11: `mem_req` and `mem_addr` stay steady until `mem_ack`. `mem_req` and `refill_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a check (taken when not busy) |
| req_addr | input | AW | Address to check |
| busy | output | 1 | A check is in progress |
| done | output | 1 | One-cycle completion pulse |
| is_valid | output | 1 | Address is an instruction start (with done) |
| cfg_err | output | 1 | Overlapping cached sections (with done) |
| res_addr | output | AW | Address the result belongs to |
| refill_req | output | 1 | Descriptor refill request |
| refill_addr | output | AW | Address needing a descriptor |
| refill_ack | input | 1 | Refill reply strobe |
| refill_hit | input | 1 | Reply carries a covering descriptor |
| refill_start | input | AW | Reply: first byte of section |
| refill_end | input | AW | Reply: last byte of section |
| refill_ptr | input | AW | Reply: bitmap base address |
| mem_req | output | 1 | Bitmap byte read request |
| mem_addr | output | AW | Bitmap byte address |
| mem_ack | input | 1 | Read data strobe |
| mem_rdata | input | 8 | Bitmap byte |

## Verification
The hardest case to reach is two cached descriptors that both cover one address. The refill agent only ever returns a single covering section, so this case cannot arise from one request. The bench first checks an address that only the first section covers, then one that only an overlapping second section covers, so both are installed. It then checks an address in their overlap. Round-robin replacement is another hidden state. It is observed through the count of refill requests: the bench installs five distinct sections, then checks which earlier sections still hit.

// File: rtl/csec_pkg.sv
package csec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_MEM  = 2'd2,
        ST_FILL = 2'd3
    } chk_st_e;

endpackage

// File: rtl/csec_range_cache.sv
// Small fully associative cache of code-section descriptors with
// parallel inclusive range compare and round-robin replacement.
module csec_range_cache #(
    parameter int AW   = 32,
    parameter int NENT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] look_addr,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_start,
    input  logic [AW-1:0] wr_end,
    input  logic [AW-1:0] wr_ptr,
    output logic          hit,
    output logic          multi,
    output logic [AW-1:0] hit_start,
    output logic [AW-1:0] hit_ptr
);
    localparam int IW = (NENT > 1) ? $clog2(NENT) : 1;
    localparam logic [IW-1:0] LAST = IW'(NENT - 1);

    typedef struct packed {
        logic [NENT-1:0]         vld;
        logic [NENT-1:0][AW-1:0] lo;
        logic [NENT-1:0][AW-1:0] hi;
        logic [NENT-1:0][AW-1:0] ptr;
        logic [IW-1:0]           vic;
    } tab_t;

    tab_t q, d;
    logic [NENT-1:0] match;

    for (genvar i = 0; i < NENT; i++) begin : g_cmp
        assign match[i] = q.vld[i] && (q.lo[i] <= look_addr) && (look_addr <= q.hi[i]);
    end

    assign hit   = |match;
    assign multi = (match & (match - NENT'(1))) != '0;

    always_comb begin
        hit_start = '0;
        hit_ptr   = '0;
        for (int i = 0; i < NENT; i++) begin
            if (match[i]) begin
                hit_start = hit_start | q.lo[i];
                hit_ptr   = hit_ptr | q.ptr[i];
            end
        end
    end

    always_comb begin
        d = q;
        if (wr_en) begin
            d.vld[q.vic] = 1'b1;
            d.lo[q.vic]  = wr_start;
            d.hi[q.vic]  = wr_end;
            d.ptr[q.vic] = wr_ptr;
            d.vic        = (q.vic == LAST) ? '0 : q.vic + IW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/csec_bit_locate.sv
// Maps an address inside a section to its bitmap byte and bit.
module csec_bit_locate #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] sec_start,
    input  logic [AW-1:0] map_base,
    output logic [AW-1:0] byte_addr,
    output logic [2:0]    bit_idx
);
    logic [AW-1:0] off;

    always_comb begin
        off       = addr - sec_start;
        byte_addr = map_base + (off >> 3);
        bit_idx   = off[2:0];
    end

endmodule

// File: rtl/csec_bitmap_chk.sv
module csec_bitmap_chk
    import csec_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NENT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          busy,
    output logic          done,
    output logic          is_valid,
    output logic          cfg_err,
    output logic [AW-1:0] res_addr,
    output logic          refill_req,
    output logic [AW-1:0] refill_addr,
    input  logic          refill_ack,
    input  logic          refill_hit,
    input  logic [AW-1:0] refill_start,
    input  logic [AW-1:0] refill_end,
    input  logic [AW-1:0] refill_ptr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [7:0]    mem_rdata
);
    typedef struct packed {
        chk_st_e       st;
        logic [AW-1:0] addr;
        logic [AW-1:0] maddr;
        logic [2:0]    bidx;
        logic          refilled;
        logic          done;
        logic          ok;
        logic          err;
    } ctl_t;

    ctl_t q, d;

    logic          c_hit, c_multi, c_wr;
    logic [AW-1:0] c_start, c_ptr;
    logic [AW-1:0] l_byte;
    logic [2:0]    l_bit;

    assign c_wr = (q.st == ST_FILL) && refill_ack && refill_hit;

    csec_range_cache #(.AW(AW), .NENT(NENT)) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_addr (q.addr),
        .wr_en     (c_wr),
        .wr_start  (refill_start),
        .wr_end    (refill_end),
        .wr_ptr    (refill_ptr),
        .hit       (c_hit),
        .multi     (c_multi),
        .hit_start (c_start),
        .hit_ptr   (c_ptr)
    );

    csec_bit_locate #(.AW(AW)) u_loc (
        .addr      (q.addr),
        .sec_start (c_start),
        .map_base  (c_ptr),
        .byte_addr (l_byte),
        .bit_idx   (l_bit)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.ok   = 1'b0;
        d.err  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr     = req_addr;
                    d.refilled = 1'b0;
                    d.st       = ST_LOOK;
                end
            end
            ST_LOOK: begin
                if (c_multi) begin
                    d.done = 1'b1;
                    d.err  = 1'b1;
                    d.st   = ST_IDLE;
                end else if (c_hit) begin
                    d.maddr = l_byte;
                    d.bidx  = l_bit;
                    d.st    = ST_MEM;
                end else if (q.refilled) begin
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end else begin
                    d.st = ST_FILL;
                end
            end
            ST_FILL: begin
                if (refill_ack) begin
                    if (refill_hit) begin
                        d.refilled = 1'b1;
                        d.st       = ST_LOOK;
                    end else begin
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end
                end
            end
            ST_MEM: begin
                if (mem_ack) begin
                    d.done = 1'b1;
                    d.ok   = mem_rdata[q.bidx];
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy        = (q.st != ST_IDLE);
    assign done        = q.done;
    assign is_valid    = q.ok;
    assign cfg_err     = q.err;
    assign res_addr    = q.addr;
    assign refill_req  = (q.st == ST_FILL);
    assign refill_addr = q.addr;
    assign mem_req     = (q.st == ST_MEM);
    assign mem_addr    = q.maddr;

endmodule

// File: rtl/csec_chk_sva.sv
module csec_chk_sva #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          is_valid,
    input logic          cfg_err,
    input logic          refill_req,
    input logic          refill_ack,
    input logic [AW-1:0] refill_addr,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr
);
    p_verdict_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!is_valid && !cfg_err));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    p_one_port_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && refill_req));

    p_fill_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && !refill_ack) |=> (refill_req && $stable(refill_addr)));

    p_err_rejects_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !is_valid);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !refill_req));

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind csec_bitmap_chk csec_chk_sva #(.AW(AW)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .is_valid    (is_valid),
    .cfg_err     (cfg_err),
    .refill_req  (refill_req),
    .refill_ack  (refill_ack),
    .refill_addr (refill_addr),
    .mem_req     (mem_req),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr)
);

// File: tb/sim_csec_bitmap_chk.sv
`timescale 1ns/1ps
module sim_csec_bitmap_chk;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        busy, done, is_valid, cfg_err;
    logic [31:0] res_addr;
    logic        refill_req;
    logic [31:0] refill_addr;
    logic        refill_ack = 1'b0, refill_hit = 1'b0;
    logic [31:0] refill_start = '0, refill_end = '0, refill_ptr = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;

    int n_tests = 0, n_fail = 0, n_fill = 0, n_rd = 0;
    logic r_ok, r_err, r_done;
    logic [31:0] r_addr;

    always #5 clk = ~clk;

    csec_bitmap_chk u0 (.*);

    // Section table held by the external agent.
    localparam int NS = 6;
    localparam logic [31:0] OS_LO [NS] = '{32'h1000, 32'h2003, 32'h3000, 32'h4000, 32'h6000, 32'h10F0};
    localparam logic [31:0] OS_HI [NS] = '{32'h10FF, 32'h2040, 32'h3FFF, 32'h40FF, 32'h60FF, 32'h1200};
    localparam logic [31:0] OS_PT [NS] = '{32'h8000, 32'h9000, 32'hA000, 32'hB000, 32'hC000, 32'hD000};

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'hA5;
    endfunction

    // {found, bit} from R2/R3, first covering section.
    function automatic logic [1:0] expect_bit(input logic [31:0] a);
        for (int i = 0; i < NS; i++) begin
            if (OS_LO[i] <= a && a <= OS_HI[i]) begin
                logic [31:0] off;
                logic [7:0]  b;
                off = a - OS_LO[i];
                b   = mbyte(OS_PT[i] + (off >> 3));
                return {1'b1, b[off[2:0]]};
            end
        end
        return 2'b00;
    endfunction

    always @(negedge clk) begin
        if (refill_req && !refill_ack) begin
            refill_ack = 1'b1;
            refill_hit = 1'b0;
            n_fill++;
            for (int i = NS - 1; i >= 0; i--) begin
                if (OS_LO[i] <= refill_addr && refill_addr <= OS_HI[i]) begin
                    refill_hit   = 1'b1;
                    refill_start = OS_LO[i];
                    refill_end   = OS_HI[i];
                    refill_ptr   = OS_PT[i];
                end
            end
        end else begin
            refill_ack = 1'b0;
        end
        if (mem_req && !mem_ack) begin
            mem_ack   = 1'b1;
            mem_rdata = mbyte(mem_addr);
            n_rd++;
        end else begin
            mem_ack = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done && t < 300) begin
            @(negedge clk);
            t++;
        end
        r_done = done;
        r_ok   = is_valid;
        r_err  = cfg_err;
        r_addr = res_addr;
        if (!done) chk("timeout waiting for done", 32'd0, 32'd1);
    endtask

    task automatic run(input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    typedef struct packed {
        logic [31:0] a;
        logic        fill;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{32'h1000, 1'b1}, '{32'h1007, 1'b0}, '{32'h10FF, 1'b0},
        '{32'h2003, 1'b1}, '{32'h2040, 1'b0}, '{32'h2041, 1'b1},
        '{32'h3ABC, 1'b1}, '{32'h0FFF, 1'b1}, '{32'h2015, 1'b0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int f0, m0;
        logic [1:0] e;
        do_reset();
        // R1 reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 reqs", 32'({mem_req, refill_req}), 0);

        // Table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            f0 = n_fill;
            m0 = n_rd;
            e  = expect_bit(VEC[v].a);
            run(VEC[v].a);
            chk($sformatf("R3 verdict @%h", VEC[v].a), 32'(r_ok), 32'(e[0]));
            chk($sformatf("R2 covered read @%h", VEC[v].a), 32'(n_rd - m0), 32'(e[1]));
            chk($sformatf("R4/R6 refill count @%h", VEC[v].a), 32'(n_fill - f0), 32'(VEC[v].fill));
            chk($sformatf("R10 res_addr @%h", VEC[v].a), r_addr, VEC[v].a);
            chk("R8 no cfg_err", 32'(r_err), 0);
            @(negedge clk);
            chk("R10 done pulse", 32'(done), 0);
            chk("R10 valid gated", 32'(is_valid), 0);
        end

        // R7 round-robin: slots hold S0,S1,S2; add S3 then S4 (evicts S0)
        run(32'h4010);
        run(32'h6020);
        f0 = n_fill;
        run(32'h2010);
        chk("R7 S1 survives", 32'(n_fill - f0), 0);
        f0 = n_fill;
        run(32'h1010);
        chk("R7 S0 evicted", 32'(n_fill - f0), 1);
        e = expect_bit(32'h1010);
        chk("R3 verdict after reinstall", 32'(r_ok), 32'(e[0]));
        f0 = n_fill;
        run(32'h3000);
        chk("R7 S2 survives", 32'(n_fill - f0), 0);
        f0 = n_fill;
        run(32'h2010);
        chk("R7 S1 evicted by reinstall", 32'(n_fill - f0), 1);

        // R8 overlapping sections
        do_reset();
        f0 = n_fill;
        run(32'h1000);
        chk("R1 refill after reset", 32'(n_fill - f0), 1);
        run(32'h1150);
        m0 = n_rd;
        run(32'h10F8);
        chk("R8 cfg_err", 32'(r_err), 1);
        chk("R8 rejected", 32'(r_ok), 0);
        chk("R8 no read", 32'(n_rd - m0), 0);

        // R9 request during busy ignored
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 32'h1004;
        @(negedge clk);
        chk("R9 busy", 32'(busy), 1);
        req_addr = 32'h1180;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        e = expect_bit(32'h1004);
        chk("R9 first address kept", r_addr, 32'h1004);
        chk("R9 first verdict", 32'(r_ok), 32'(e[0]));
        r_done = 1'b0;
        repeat (8) begin
            @(negedge clk);
            if (done) r_done = 1'b1;
        end
        chk("R9 no second completion", 32'(r_done), 0);
        chk("R9 idle after", 32'(busy), 0);

        // R5 uncovered address
        m0 = n_rd;
        run(32'h9000);
        chk("R5 rejected", 32'(r_ok), 0);
        chk("R5 no read", 32'(n_rd - m0), 0);

        finish_run();
    end
endmodule